// File: doc/BRIEF.md
# VME Transfer Timeout Monitor

This block sits beside a VME bus interface and watches each data transfer that a master makes to a slave. A transfer is timed from the moment the address strobe and the data strobe are both active. If the slave answers with its data transfer acknowledge before the limit runs out, the transfer finishes normally. If the limit runs out first, the block drives bus error so that a dead slave cannot stall the I/O path. It also raises a sticky fault flag.

When the fault flag is set, the block keeps a record of the faulting access: the address, the address modifier, whether the access was a single or a block transfer, the address space, and the backplane slot whose window holds the address. The record stays frozen until the fault is cleared through a dedicated clear input.

The strobe and acknowledge inputs are asynchronous and active low. Each one passes through a two-flop synchronizer before the timing logic uses it. The limit is a parameter in clock cycles. At 50 MHz, 2560 cycles gives 51.2 microseconds.

Top module: `vme_xfer_watchdog`

## Requirements
- R1: After reset, bus_err_n is 1, fault_valid is 0, and every fault field reads 0.
- R2: Timing starts only while both as_n and ds_n are low. With only as_n low, bus_err_n stays 1 however long it lasts.
- R3: Suppose both strobes are low, dtack_n stays high, and the strobes are first seen at a rising edge E. Then bus_err_n falls exactly at edge E+TIMEOUT_CYCLES+2: two synchronizer stages plus the state register. fault_valid rises on the same edge.
- R4: A dtack_n low that arrives before the limit ends the transfer. bus_err_n stays 1 and no fault is logged.
- R5: Once asserted, bus_err_n stays low while as_n is low. It returns to 1 three rising edges after as_n goes high.
- R6: Each data strobe assertion is timed on its own. With as_n held low, a series of acknowledged data strobes whose total time exceeds the limit causes no bus error.
- R7: On a timeout, fault_addr and fault_am capture the addr and am inputs. fault_valid then stays 1 until fault_clr is high at a rising edge, and it reads 0 after that edge.
- R8: fault_kind encodes the modifier as follows: 1 (single) for 0x09, 0x0A, 0x0D, 0x0E, 0x39, 0x3A, 0x3D, 0x3E; 2 (block) for 0x08, 0x0B, 0x0C, 0x0F, 0x38, 0x3B, 0x3C, 0x3F; 0 for anything else.
- R9: For an A32 modifier (0x08 to 0x0F) and an address in 0x50000000 to 0x7FFFFFFF, fault_slot is 3 + (addr - 0x50000000) / 0x08000000. For any other access fault_slot is 0.
- R10: fault_space is 2 for any A32 modifier. It is 1 for an A24 modifier (0x38 to 0x3F) whose low 24 address bits are at most 0xBFFFFF. Otherwise it is 0.
- R11: While fault_valid is 1, a further timeout still drives bus error but leaves the logged record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| dtack_n | input | 1 | Data transfer acknowledge, active low, asynchronous |
| addr | input | 32 | Bus address of the current transfer |
| am | input | 6 | Address modifier of the current transfer |
| fault_clr | input | 1 | Clears the logged fault |
| bus_err_n | output | 1 | Bus error, active low |
| fault_valid | output | 1 | Sticky timeout fault flag |
| fault_addr | output | 32 | Address of the logged fault |
| fault_am | output | 6 | Address modifier of the logged fault |
| fault_kind | output | 2 | 0 other, 1 single, 2 block |
| fault_space | output | 2 | 0 none, 1 A24, 2 A32 |
| fault_slot | output | 4 | Slot number, 0 outside the slot windows |

## Verification
The assertions check a set of properties on every cycle:
- The cycle counter never reaches the limit.
- The timer never jumps from idle straight to error.
- An acknowledged transfer never errors.
- Bus error cannot drop while the address strobe is held.
- A valid record neither vanishes nor changes without a clear.
- The slot number is always 0 or inside the slot range.

Other behaviour can only be shown by the bench's scenarios:
- The exact edge on which bus error rises and falls.
- The per-strobe restart during block transfers.
- The modifier, space and slot decoding for particular addresses.

// File: rtl/vme_wd_pkg.sv
package vme_wd_pkg;

    localparam int ADDR_W     = 32;
    localparam int AM_W       = 6;
    localparam int SLOT_W     = 4;
    localparam int SLOT_FIRST = 3;
    localparam int SLOT_COUNT = 6;
    localparam int SLOT_SHIFT = 27;
    localparam logic [ADDR_W-1:0] SLOT_BASE = 32'h5000_0000;
    localparam logic [23:0] A24_TOP = 24'hBF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_ACKED  = 2'd2,
        ST_ERROR  = 2'd3
    } wd_state_e;

    typedef enum logic [1:0] {
        KIND_OTHER  = 2'd0,
        KIND_SINGLE = 2'd1,
        KIND_BLOCK  = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SPACE_NONE = 2'd0,
        SPACE_A24  = 2'd1,
        SPACE_A32  = 2'd2
    } xfer_space_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [AM_W-1:0]   am;
        xfer_kind_e        kind;
        xfer_space_e       space;
        logic [SLOT_W-1:0] slot;
    } fault_rec_t;

    function automatic xfer_kind_e kind_of(input logic [AM_W-1:0] m);
        case (m)
            6'h09, 6'h0A, 6'h0D, 6'h0E,
            6'h39, 6'h3A, 6'h3D, 6'h3E: kind_of = KIND_SINGLE;
            6'h08, 6'h0B, 6'h0C, 6'h0F,
            6'h38, 6'h3B, 6'h3C, 6'h3F: kind_of = KIND_BLOCK;
            default:                    kind_of = KIND_OTHER;
        endcase
    endfunction

    function automatic xfer_space_e space_of(input logic [AM_W-1:0] m,
                                             input logic [ADDR_W-1:0] a);
        if (m[5:3] == 3'b001)
            space_of = SPACE_A32;
        else if (m[5:3] == 3'b111 && a[23:0] <= A24_TOP)
            space_of = SPACE_A24;
        else
            space_of = SPACE_NONE;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] idx;
        off = a - SLOT_BASE;
        idx = off >> SLOT_SHIFT;
        if (a >= SLOT_BASE && idx < ADDR_W'(SLOT_COUNT))
            slot_of = SLOT_W'(idx + ADDR_W'(SLOT_FIRST));
        else
            slot_of = '0;
    endfunction

endpackage

// File: rtl/vme_wd_sync.sv
module vme_wd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= INIT;
            else if (s == 0)
                stage_q[s] <= din;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/vme_wd_timer.sv
module vme_wd_timer
    import vme_wd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 2560
) (
    input  logic clk,
    input  logic rst,
    input  logic as_act,
    input  logic ds_act,
    input  logic ack_act,
    output logic berr,
    output logic timeout_evt
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    wd_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        timeout_evt = 1'b0;
        case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (as_act && ds_act)
                    state_d = ack_act ? ST_ACKED : ST_TIMING;
            end
            ST_TIMING: begin
                if (!as_act || !ds_act) begin
                    state_d = ST_IDLE;
                end else if (ack_act) begin
                    state_d = ST_ACKED;
                end else if (cnt_q == LAST) begin
                    state_d     = ST_ERROR;
                    timeout_evt = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ACKED: begin
                if (!as_act || !ds_act)
                    state_d = ST_IDLE;
            end
            ST_ERROR: begin
                if (!as_act)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign berr = (state_q == ST_ERROR);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(TIMEOUT_CYCLES));
    // R3
    no_idle_jump_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |=> state_q != ST_ERROR);
    // R4
    ack_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TIMING && ack_act) |=> state_q != ST_ERROR);
    // R5
    berr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (berr && as_act) |=> berr);
endmodule

// File: rtl/vme_wd_fault_log.sv
module vme_wd_fault_log
    import vme_wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              timeout_evt,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AM_W-1:0]   am,
    output logic              valid,
    output fault_rec_t        rec
);
    logic       valid_q;
    fault_rec_t rec_q, rec_new;

    always_comb begin
        rec_new.addr  = addr;
        rec_new.am    = am;
        rec_new.kind  = kind_of(am);
        rec_new.space = space_of(am, addr);
        rec_new.slot  = (rec_new.space == SPACE_A32) ? slot_of(addr) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rec_q   <= '0;
        end else if (timeout_evt && (!valid_q || clr)) begin
            valid_q <= 1'b1;
            rec_q   <= rec_new;
        end else if (clr) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign rec   = rec_q;

    // R7
    sticky_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !clr) |=> valid_q);
    // R11
    frozen_rec_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !clr) |=> $stable(rec_q));
    // R9
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        rec_q.slot == '0 ||
        (rec_q.slot >= SLOT_W'(SLOT_FIRST) &&
         rec_q.slot <  SLOT_W'(SLOT_FIRST + SLOT_COUNT)));
endmodule

// File: rtl/vme_xfer_watchdog.sv
module vme_xfer_watchdog
    import vme_wd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 2560,
    parameter int SYNC_STAGES    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        as_n,
    input  logic        ds_n,
    input  logic        dtack_n,
    input  logic [31:0] addr,
    input  logic [5:0]  am,
    input  logic        fault_clr,
    output logic        bus_err_n,
    output logic        fault_valid,
    output logic [31:0] fault_addr,
    output logic [5:0]  fault_am,
    output logic [1:0]  fault_kind,
    output logic [1:0]  fault_space,
    output logic [3:0]  fault_slot
);
    logic [2:0] strobes_sync;
    logic       berr, evt;
    fault_rec_t rec;

    vme_wd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({as_n, ds_n, dtack_n}),
        .dout (strobes_sync)
    );

    vme_wd_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .as_act      (~strobes_sync[2]),
        .ds_act      (~strobes_sync[1]),
        .ack_act     (~strobes_sync[0]),
        .berr        (berr),
        .timeout_evt (evt)
    );

    vme_wd_fault_log u_log (
        .clk         (clk),
        .rst         (rst),
        .timeout_evt (evt),
        .clr         (fault_clr),
        .addr        (addr),
        .am          (am),
        .valid       (fault_valid),
        .rec         (rec)
    );

    assign bus_err_n   = ~berr;
    assign fault_addr  = rec.addr;
    assign fault_am    = rec.am;
    assign fault_kind  = rec.kind;
    assign fault_space = rec.space;
    assign fault_slot  = rec.slot;

    // R3
    fault_with_berr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(berr) |-> fault_valid);
endmodule

// File: tb/vme_xfer_watchdog_test.sv
module vme_xfer_watchdog_test;
    localparam int LIMIT = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1, ds_n = 1'b1, dtack_n = 1'b1, fault_clr = 1'b0;
    logic [31:0] addr = '0;
    logic [5:0]  am = '0;
    logic bus_err_n, fault_valid;
    logic [31:0] fault_addr;
    logic [5:0]  fault_am;
    logic [1:0]  fault_kind, fault_space;
    logic [3:0]  fault_slot;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    vme_xfer_watchdog #(.TIMEOUT_CYCLES(LIMIT)) uut (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .dtack_n(dtack_n),
        .addr(addr), .am(am), .fault_clr(fault_clr),
        .bus_err_n(bus_err_n), .fault_valid(fault_valid),
        .fault_addr(fault_addr), .fault_am(fault_am), .fault_kind(fault_kind),
        .fault_space(fault_space), .fault_slot(fault_slot)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_bus();
        as_n = 1'b1; ds_n = 1'b1; dtack_n = 1'b1;
        clks(4);
    endtask

    task automatic clear_fault();
        fault_clr = 1'b1;
        clks(1);
        fault_clr = 1'b0;
        chk("R7 clear", fault_valid, 0);
    endtask

    // Full timeout with exact edges and logged fields
    task automatic timeout_case(input logic [31:0] a, input logic [5:0] m,
                                input logic [1:0] k, input logic [1:0] sp,
                                input logic [3:0] sl);
        addr = a; am = m; as_n = 1'b0; ds_n = 1'b0;
        clks(LIMIT + 2);
        chk("R3 not early", bus_err_n, 1);
        clks(1);
        chk("R3 berr edge", bus_err_n, 0);
        chk("R7 valid", fault_valid, 1);
        chk("R7 addr", fault_addr, a);
        chk("R7 am", 32'(fault_am), 32'(m));
        chk("R8 kind", 32'(fault_kind), 32'(k));
        chk("R10 space", 32'(fault_space), 32'(sp));
        chk("R9 slot", 32'(fault_slot), 32'(sl));
        ds_n = 1'b1;
        clks(5);
        chk("R5 held while as low", bus_err_n, 0);
        as_n = 1'b1;
        clks(2);
        chk("R5 still low", bus_err_n, 0);
        clks(1);
        chk("R5 released", bus_err_n, 1);
        clks(2);
    endtask

    task automatic as_only_case();
        as_n = 1'b0;
        clks(LIMIT + 10);
        chk("R2 as only", bus_err_n, 1);
        chk("R2 no fault", fault_valid, 0);
        release_bus();
    endtask

    task automatic ack_case();
        addr = 32'h5800_0000; am = 6'h09;
        as_n = 1'b0; ds_n = 1'b0;
        clks(10);
        dtack_n = 1'b0;
        clks(LIMIT + 5);
        chk("R4 no berr", bus_err_n, 1);
        chk("R4 no fault", fault_valid, 0);
        release_bus();
    endtask

    task automatic block_case();
        addr = 32'h6000_0000; am = 6'h0B;
        as_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ds_n = 1'b0;
            clks(20);
            dtack_n = 1'b0;
            clks(4);
            ds_n = 1'b1; dtack_n = 1'b1;
            clks(4);
            chk("R6 beat no berr", bus_err_n, 1);
        end
        chk("R6 no fault", fault_valid, 0);
        release_bus();
    endtask

    task automatic retain_case();
        timeout_case(32'h5000_1234, 6'h09, 2'd1, 2'd2, 4'd3);
        addr = 32'h7000_0000; am = 6'h0F; as_n = 1'b0; ds_n = 1'b0;
        clks(LIMIT + 3);
        chk("R11 second berr", bus_err_n, 0);
        chk("R11 addr kept", fault_addr, 32'h5000_1234);
        chk("R11 am kept", 32'(fault_am), 32'h09);
        release_bus();
        clear_fault();
    endtask

    initial begin
        clks(3);
        rst = 1'b0;
        clks(1);
        chk("R1 berr", bus_err_n, 1);
        chk("R1 valid", fault_valid, 0);
        chk("R1 addr", fault_addr, 0);
        chk("R1 slot", 32'(fault_slot), 0);
        as_only_case();
        ack_case();
        block_case();
        retain_case();
        timeout_case(32'h7FFF_FFF0, 6'h0F, 2'd2, 2'd2, 4'd8); clear_fault();
        timeout_case(32'h1000_0000, 6'h0D, 2'd1, 2'd2, 4'd0); clear_fault();
        timeout_case(32'h00BF_FFFC, 6'h3C, 2'd2, 2'd1, 4'd0); clear_fault();
        timeout_case(32'h00C0_0000, 6'h3A, 2'd1, 2'd0, 4'd0); clear_fault();
        timeout_case(32'h6800_0010, 6'h2D, 2'd0, 2'd0, 4'd0); clear_fault();
        timeout_case(32'h6C00_0000, 6'h0C, 2'd2, 2'd2, 4'd6); clear_fault();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule